// File: doc/BRIEF.md
# Event Capture and Interrupt Controller

This block collects single-cycle pulses from a set of event sources into a sticky event register. Each bit stays set until software reads the register. A per-bit enable mask is loaded as two byte-wide control words. The interrupt line goes high while any latched bit is also enabled, whether that bit was latched before or after its enable was set.

Software reads the register in a bracketed sequence:
- A read-start pulse copies the register into a snapshot buffer and clears the register on the same clock edge. The snapshot is presented to a serial shifter outside this block.
- A read-end pulse closes the sequence and pulls the interrupt low.
- Events that arrive while the read is open, including one in the same cycle as the read-start, land in the cleared register. None is lost.
- After read-end the interrupt stays low for a fixed number of clock cycles. It then goes high again if enabled events are still latched, which makes a new interrupt edge visible to the host.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the event register, snapshot buffer, both mask words and the interrupt output are all zero; with zero masks no event raises the interrupt.
- R2: An event pulse on input bit i sets register bit i, whether or not it is enabled, and the bit stays set until a read-start clears the register.
- R3: A write with `mask_lo_wr` loads `mask_wdata[7:0]` as the enables of events 7..0; a write with `mask_hi_wr` loads `mask_wdata[3:0]` as the enables of events 11..8, and `mask_wdata[7:4]` has no effect on it.
- R4: Outside a read and outside the low window, `irq` equals, one cycle later, the OR of the latched event bits ANDed with the mask; removing or restoring a mask bit lowers or raises `irq` accordingly.
- R5: An accepted `rd_start` copies the register to `snap_data` and clears the register on the same edge; `snap_data` then holds until the next accepted `rd_start`.
- R6: An event pulse present in the same cycle as an accepted `rd_start` is written into the cleared register and not into the snapshot.
- R7: While a read is open `irq` keeps the value it took on the read-start edge; the edge that samples `rd_end` drives `irq` low.
- R8: After that edge `irq` stays low for exactly `LOW_CYCLES` cycles and then follows the enabled latched events again, so an enabled event that arrived during the read raises `irq` once the window ends.
- R9: `rd_start` while a read is open is ignored (no snapshot, no clear), and `rd_end` with no read open is ignored (the interrupt is not dropped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | N_EVT | One-cycle event pulses, one bit per source |
| mask_lo_wr | input | 1 | Load enable word for events 7..0 |
| mask_hi_wr | input | 1 | Load enable word for the upper events |
| mask_wdata | input | WORD_W | Mask word data |
| rd_start | input | 1 | Opens a read: snapshot and clear |
| rd_end | input | 1 | Closes a read: release the interrupt |
| snap_data | output | N_EVT | Snapshot buffer, right-justified, for the serial shifter |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with 12 events, byte-wide mask words and `LOW_CYCLES` = 5. With a five-cycle window, each cycle of the low window after a read can be checked individually, including the exact cycle in which the interrupt returns. With twelve sources, every event can be swept against every single-bit mask, a 12 by 12 grid that covers both mask words and their bit mapping. The expected values of the register and the interrupt are derived arithmetically from the bit index and the mask bit for each case.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the event capture and interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package evt_irq_pkg;

    // Phase of the interrupt sequencer.
    typedef enum logic [1:0] {
        PH_LIVE = 2'd0,   // irq follows the enabled latched events
        PH_READ = 2'd1,   // read open, irq frozen
        PH_GAP  = 2'd2    // forced-low window after a read
    } irq_phase_t;

endpackage

// File: rtl/evt_latch.sv
`timescale 1ns/1ps
// Module: evt_latch
// Sticky event register plus snapshot buffer. On snap_take the register is
// copied to the buffer and cleared on the same edge; pulses in that cycle are
// written into the cleared register.
// Assumes: evt_pulse bits are single-cycle pulses synchronous to clk.
module evt_latch #(
    parameter int N_EVT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_pulse,
    input  logic             snap_take,
    output logic [N_EVT-1:0] evt_q,
    output logic [N_EVT-1:0] snap_q
);

    // Latch events, and snapshot-and-clear on an accepted read start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            snap_q <= '0;
        end else begin
            evt_q <= (snap_take ? '0 : evt_q) | evt_pulse;
            if (snap_take) begin
                snap_q <= evt_q;
            end
        end
    end

endmodule

// File: rtl/evt_mask.sv
`timescale 1ns/1ps
// Module: evt_mask
// Holds the interrupt enable mask, written as two words. The low word enables
// events WORD_W-1..0; the low HI_W bits of the high word enable the rest.
// Assumes: WORD_W < N_EVT <= 2*WORD_W.
module evt_mask #(
    parameter int N_EVT  = 12,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [N_EVT-1:0]  mask_q
);

    localparam int HI_W = N_EVT - WORD_W;

    logic [WORD_W-1:0] lo_q;

    // Low mask word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (wr_lo) begin
            lo_q <= wdata;
        end
    end

    generate
        if (HI_W > 0) begin : g_hi
            logic [HI_W-1:0] hi_q;

            // High mask word register; data bits above HI_W are dropped.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hi_q <= '0;
                end else if (wr_hi) begin
                    hi_q <= wdata[HI_W-1:0];
                end
            end

            assign mask_q = {hi_q, lo_q};
        end else begin : g_lo_only
            logic unused_hi;
            assign unused_hi = wr_hi;
            assign mask_q    = lo_q[N_EVT-1:0];
        end
    endgenerate

endmodule

// File: rtl/irq_gen.sv
`timescale 1ns/1ps
// Module: irq_gen
// Read sequencer and interrupt output. Outside a read, irq follows pending one
// cycle late. During a read irq is frozen; read end forces irq low for
// LOW_CYCLES cycles before it follows pending again.
// Assumes: LOW_CYCLES >= 1; rd_start and rd_end are single-cycle pulses.
module irq_gen
    import evt_irq_pkg::*;
#(
    parameter int LOW_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic rd_start,
    input  logic rd_end,
    output logic snap_take,
    output logic busy,
    output logic gap_active,
    output logic irq
);

    localparam int CNT_W = $clog2(LOW_CYCLES + 1);

    irq_phase_t       phase;
    logic [CNT_W-1:0] gap_cnt;
    logic             irq_q;

    // Sequence read phases, count the low window, and drive irq.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_LIVE;
            gap_cnt <= '0;
            irq_q   <= 1'b0;
        end else begin
            case (phase)
                PH_LIVE: begin
                    irq_q <= pending;
                    if (rd_start) begin
                        phase <= PH_READ;
                    end
                end
                PH_READ: begin
                    if (rd_end) begin
                        irq_q   <= 1'b0;
                        gap_cnt <= CNT_W'(LOW_CYCLES - 1);
                        phase   <= PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (gap_cnt == '0) begin
                        irq_q <= pending;
                        phase <= rd_start ? PH_READ : PH_LIVE;
                    end else if (rd_start) begin
                        gap_cnt <= '0;
                        phase   <= PH_READ;
                    end else begin
                        gap_cnt <= gap_cnt - CNT_W'(1);
                    end
                end
                default: phase <= PH_LIVE;
            endcase
        end
    end

    // A read start is accepted whenever no read is open.
    assign snap_take  = rd_start && (phase != PH_READ);
    assign busy       = (phase == PH_READ);
    assign gap_active = (phase == PH_GAP) && (gap_cnt != '0);
    assign irq        = irq_q;

endmodule

// File: rtl/evt_irq_ctrl.sv
`timescale 1ns/1ps
// Module: evt_irq_ctrl (top)
// Event capture and interrupt controller: sticky event register, two-word
// enable mask, snapshot-and-clear read with a post-read interrupt low window.
// Assumes: WORD_W < N_EVT <= 2*WORD_W, LOW_CYCLES >= 1, synchronous inputs.
module evt_irq_ctrl #(
    parameter int N_EVT      = 12,
    parameter int WORD_W     = 8,
    parameter int LOW_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_pulse,
    input  logic              mask_lo_wr,
    input  logic              mask_hi_wr,
    input  logic [WORD_W-1:0] mask_wdata,
    input  logic              rd_start,
    input  logic              rd_end,
    output logic [N_EVT-1:0]  snap_data,
    output logic              irq
);

    logic [N_EVT-1:0] evt_q;
    logic [N_EVT-1:0] mask_q;
    logic             pending;
    logic             snap_take;
    logic             busy;
    logic             gap_active;

    evt_latch #(.N_EVT(N_EVT)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .snap_take (snap_take),
        .evt_q     (evt_q),
        .snap_q    (snap_data)
    );

    evt_mask #(.N_EVT(N_EVT), .WORD_W(WORD_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (mask_lo_wr),
        .wr_hi  (mask_hi_wr),
        .wdata  (mask_wdata),
        .mask_q (mask_q)
    );

    // Any latched event that is also enabled requests the interrupt.
    assign pending = |(evt_q & mask_q);

    irq_gen #(.LOW_CYCLES(LOW_CYCLES)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .rd_start   (rd_start),
        .rd_end     (rd_end),
        .snap_take  (snap_take),
        .busy       (busy),
        .gap_active (gap_active),
        .irq        (irq)
    );

endmodule

// File: rtl/evt_irq_chk.sv
`timescale 1ns/1ps
// Module: evt_irq_chk
// Assertion checker bound into evt_irq_ctrl. Relates the event register,
// snapshot, mask and read phase to the interrupt output over time.
// Assumes: bound with the top's internal nets evt_q, mask_q, busy, gap_active.
module evt_irq_chk #(
    parameter int N_EVT = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_EVT-1:0] evt_pulse,
    input logic             rd_start,
    input logic             rd_end,
    input logic [N_EVT-1:0] evt_q,
    input logic [N_EVT-1:0] mask_q,
    input logic [N_EVT-1:0] snap_data,
    input logic             busy,
    input logic             gap_active,
    input logic             irq
);

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_start && !busy) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !gap_active) |=> (irq == $past(|(evt_q & mask_q))));

    p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !busy) |=> (snap_data == $past(evt_q)));

    p_same_cycle_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !busy) |=> (evt_q == $past(evt_pulse)));

    p_hold_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_end) |=> (irq == $past(irq)));

    p_drop_on_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_end) |=> !irq);

    p_low_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gap_active |=> !irq);

    p_restart_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_start && !rd_end) |=> $stable(snap_data));

endmodule

bind evt_irq_ctrl evt_irq_chk #(.N_EVT(N_EVT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_pulse  (evt_pulse),
    .rd_start   (rd_start),
    .rd_end     (rd_end),
    .evt_q      (evt_q),
    .mask_q     (mask_q),
    .snap_data  (snap_data),
    .busy       (busy),
    .gap_active (gap_active),
    .irq        (irq)
);

// File: tb/sim_evt_irq_ctrl.sv
`timescale 1ns/1ps
// Bench for evt_irq_ctrl: directed scenarios plus a full event-by-mask sweep.
module sim_evt_irq_ctrl;

    localparam int NE = 12;
    localparam int WW = 8;
    localparam int LC = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NE-1:0] evt_pulse;
    logic          mask_lo_wr;
    logic          mask_hi_wr;
    logic [WW-1:0] mask_wdata;
    logic          rd_start;
    logic          rd_end;
    logic [NE-1:0] snap_data;
    logic          irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    evt_irq_ctrl #(.N_EVT(NE), .WORD_W(WW), .LOW_CYCLES(LC)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_pulse  (evt_pulse),
        .mask_lo_wr (mask_lo_wr),
        .mask_hi_wr (mask_hi_wr),
        .mask_wdata (mask_wdata),
        .rd_start   (rd_start),
        .rd_end     (rd_end),
        .snap_data  (snap_data),
        .irq        (irq)
    );

    // Advance one edge; inputs change and outputs are sampled 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [NE-1:0] v);
        evt_pulse = v;
        tick();
        evt_pulse = '0;
    endtask

    task automatic wr_masks(input logic [WW-1:0] lo, input logic [WW-1:0] hi);
        mask_wdata = lo; mask_lo_wr = 1'b1;
        tick();
        mask_lo_wr = 1'b0; mask_wdata = hi; mask_hi_wr = 1'b1;
        tick();
        mask_hi_wr = 1'b0; mask_wdata = '0;
    endtask

    task automatic rd_begin();
        rd_start = 1'b1;
        tick();
        rd_start = 1'b0;
    endtask

    task automatic rd_finish();
        rd_end = 1'b1;
        tick();
        rd_end = 1'b0;
    endtask

    task automatic full_read();
        rd_begin();
        rd_finish();
        repeat (LC) tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; evt_pulse = '0; mask_lo_wr = 1'b0; mask_hi_wr = 1'b0;
        mask_wdata = '0; rd_start = 1'b0; rd_end = 1'b0;
        repeat (3) tick();
        chk("R1 irq in reset", 32'(irq), 32'd0);
        chk("R1 snap in reset", 32'(snap_data), 32'd0);
        rst_n = 1'b1;
        tick();

        // R1: register empty after reset; masks zero.
        full_read();
        chk("R1 register empty", 32'(snap_data), 32'd0);
        pulse('1);
        tick();
        chk("R1 zero masks keep irq low", 32'(irq), 32'd0);
        // R2: latched regardless of mask.
        full_read();
        chk("R2 all latched unmasked", 32'(snap_data), 32'hFFF);

        // R2: sticky sweep, two events separated in time.
        for (int i = 0; i < NE; i++) begin
            logic [NE-1:0] a;
            logic [NE-1:0] b;
            a = NE'(1) << i;
            b = NE'(1) << ((i + 5) % NE);
            pulse(a);
            repeat (3) tick();
            pulse(b);
            full_read();
            chk("R2 sticky pair", 32'(snap_data), 32'(a | b));
        end

        // R3/R4: every single-bit mask against every event.
        for (int m = 0; m < NE; m++) begin
            logic [WW-1:0] lo;
            logic [WW-1:0] hi;
            lo = (m < WW) ? (WW'(1) << m) : '0;
            hi = 8'hF0 | ((m >= WW) ? (WW'(1) << (m - WW)) : 8'h00);
            wr_masks(lo, hi);
            for (int j = 0; j < NE; j++) begin
                pulse(NE'(1) << j);
                tick();
                chk("R3 R4 mask mapping", 32'(irq), 32'(j == m));
                full_read();
                chk("R4 low with nothing pending", 32'(irq), 32'd0);
            end
        end

        // R4: removing and restoring the mask.
        wr_masks(8'hFF, 8'h0F);
        pulse(12'h010);
        tick();
        chk("R4 enabled event", 32'(irq), 32'd1);
        wr_masks(8'h00, 8'h00);
        chk("R4 mask removed", 32'(irq), 32'd0);
        wr_masks(8'hFF, 8'h0F);
        chk("R4 mask restored", 32'(irq), 32'd1);
        full_read();
        chk("R4 latched bit kept while masked", 32'(snap_data), 32'h010);

        // R5: snapshot, hold, clear.
        wr_masks(8'h00, 8'h00);
        pulse(12'h0A5);
        rd_begin();
        chk("R5 snapshot", 32'(snap_data), 32'h0A5);
        repeat (4) tick();
        chk("R5 hold during read", 32'(snap_data), 32'h0A5);
        rd_finish();
        repeat (LC) tick();
        chk("R5 hold after read", 32'(snap_data), 32'h0A5);
        full_read();
        chk("R5 register cleared", 32'(snap_data), 32'h000);

        // R6: event in the snapshot cycle goes to the register.
        pulse(12'h001);
        evt_pulse = 12'h800; rd_start = 1'b1;
        tick();
        evt_pulse = '0; rd_start = 1'b0;
        chk("R6 snapshot excludes same-cycle event", 32'(snap_data), 32'h001);
        rd_finish();
        repeat (LC) tick();
        full_read();
        chk("R6 same-cycle event kept", 32'(snap_data), 32'h800);

        // R7/R8: irq held high, dropped, low window, re-raised.
        wr_masks(8'hFF, 8'h0F);
        pulse(12'h001);
        tick();
        chk("R7 irq before read", 32'(irq), 32'd1);
        rd_begin();
        chk("R7 irq held at read start", 32'(irq), 32'd1);
        pulse(12'h010);
        repeat (3) tick();
        chk("R7 irq held in read", 32'(irq), 32'd1);
        rd_finish();
        chk("R7 irq dropped at read end", 32'(irq), 32'd0);
        for (int k = 1; k < LC; k++) begin
            tick();
            chk("R8 low window", 32'(irq), 32'd0);
        end
        tick();
        chk("R8 re-raised after window", 32'(irq), 32'd1);
        full_read();
        chk("R8 mid-read event kept", 32'(snap_data), 32'h010);
        chk("R8 low after clean read", 32'(irq), 32'd0);

        // R7/R8: read opened with irq low stays low, then rises.
        rd_begin();
        pulse(12'h100);
        repeat (2) tick();
        chk("R7 irq held low in read", 32'(irq), 32'd0);
        rd_finish();
        repeat (LC - 1) tick();
        chk("R8 still low at window end", 32'(irq), 32'd0);
        tick();
        chk("R8 rises after window", 32'(irq), 32'd1);
        full_read();
        rd_begin();
        rd_finish();
        repeat (LC) tick();
        chk("R8 stays low with nothing pending", 32'(irq), 32'd0);

        // R9: second start ignored; stray end ignored.
        wr_masks(8'h00, 8'h00);
        pulse(12'h003);
        rd_begin();
        chk("R9 first snapshot", 32'(snap_data), 32'h003);
        pulse(12'h00C);
        rd_start = 1'b1;
        tick();
        rd_start = 1'b0;
        chk("R9 restart ignored", 32'(snap_data), 32'h003);
        rd_finish();
        repeat (LC) tick();
        full_read();
        chk("R9 register not cleared by restart", 32'(snap_data), 32'h00C);
        wr_masks(8'hFF, 8'h0F);
        pulse(12'h040);
        tick();
        chk("R9 irq before stray end", 32'(irq), 32'd1);
        rd_end = 1'b1;
        tick();
        rd_end = 1'b0;
        chk("R9 stray end ignored", 32'(irq), 32'd1);
        tick();
        chk("R9 irq still high", 32'(irq), 32'd1);
        full_read();

        summary();
        $finish;
    end

endmodule